// File: doc/BRIEF.md
# Presettable Synchronous Decade Counter Digit

This block is one BCD digit of a synchronous counter. It counts 0 through 9 on the rising clock edge and returns to 0 after 9. It has an active-low clear that acts at once, without a clock edge. It also has an active-low synchronous parallel load. Two count enables must both be high for the digit to advance. Only one of the two, `carry_en`, takes part in the terminal-count output `tc`.

Because `tc` is decoded combinationally from the state and `carry_en`, digits are chained by wiring each digit's `tc` to the `carry_en` of the next digit. `cnt_en` and the clock are shared by all digits, so the whole chain advances on one common edge by look-ahead, with no ripple.

A loaded value from 10 to 15 is out of range. It stays until the next count-enabled edge, which returns the digit to 0.

The block has no data stream, so there is no valid/ready interface. Every pin is a plain control or status level.

Top module: `bcd_digit_counter`

## Requirements
- R1: `q` changes only on a rising edge of `clk` or through the clear. Changes on `din`, `ld_n`, `cnt_en` or `carry_en` between edges leave `q` unchanged.
- R2: While `clr_n` is low, `q` is 0000 at once, without waiting for a clock edge. This holds at every edge whatever the levels of `ld_n`, `din` and both enables.
- R3: With `clr_n` high and `ld_n` low at a rising edge, `q` takes `din`. This happens whatever the levels of `cnt_en` and `carry_en`, and no count takes place on that edge.
- R4: With `ld_n` high, `q` advances on an edge only when `cnt_en` and `carry_en` are both high. Otherwise `q` holds its value.
- R5: A count-enabled edge takes `q` from n to n+1 for n in 0..8, and from 9 to 0.
- R6: `tc` is 1 exactly when `carry_en` is 1 and `q` equals 9. It follows these levels with no clock delay and does not depend on `cnt_en`.
- R7: When `q` holds 10..15, `tc` is 0, and the next count-enabled edge sets `q` to 0.
- R8: Three digits chained through `tc` to the next digit's `carry_en`, with shared `clk` and `cnt_en`, count 000 to 999 and wrap to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| clr_n | input | 1 | Clear, active low, acts at once without a clock edge |
| ld_n | input | 1 | Parallel load, active low, sampled on the rising edge |
| din | input | 4 | Value taken into the digit by a load |
| cnt_en | input | 1 | Count enable; takes no part in `tc` |
| carry_en | input | 1 | Count enable that also gates `tc`; chained from the previous digit's `tc` |
| q | output | 4 | Current digit value, BCD |
| tc | output | 1 | Terminal count: `carry_en` and `q` equal to 9 |

## Verification
A wrong step in the next-state selector shows on `q` one edge after the faulty cycle. A missed wrap at 9 or a stray increment changes the combined three-digit value at once and keeps it wrong after that. A fault in the carry path, such as `tc` wrongly gated by `cnt_en` or decoded at the wrong value, first shows on the next digit's value at the same edge at which the low digit wraps. The bench therefore sweeps the full 000..999 cycle edge by edge. It also loads every 4-bit code with both levels of `carry_en`, so a fault on the out-of-range codes or the enable gating shows within one edge.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int DIGIT_MOD = 10;
  localparam int DIGIT_W   = 4;

  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } dcnt_op_e;
endpackage

// File: rtl/dcnt_next.sv
module dcnt_next
  import dcnt_pkg::*;
#(
  parameter int MODULUS = DIGIT_MOD,
  parameter int W       = DIGIT_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  logic         ld_n,
  input  logic         cnt_en,
  input  logic         carry_en,
  output dcnt_op_e     op,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);

  logic [W-1:0] stepped;

  // Load has priority over counting; counting needs both enables.
  always_comb begin
    if (!ld_n)                  op = OP_LOAD;
    else if (cnt_en && carry_en) op = OP_STEP;
    else                        op = OP_KEEP;
  end

  // Increment variant chosen by the modulus.
  generate
    if (MODULUS == (1 << W)) begin : g_natural_wrap
      assign stepped = cur + 1'b1;
    end else begin : g_decade_wrap
      // Terminal and out-of-range values both return to zero.
      assign stepped = (cur >= TERM) ? '0 : cur + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_STEP: nxt = stepped;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dcnt_state.sv
module dcnt_state
  import dcnt_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  dcnt_op_e     op,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)              q <= '0;
    else if (op != OP_KEEP)  q <= nxt;
  end

  // R2
  clear_hold_chk: assert property (@(posedge clk) !clr_n |-> q == '0);

  // R4
  keep_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
    op == OP_KEEP |=> $stable(q));
endmodule

// File: rtl/dcnt_tc.sv
module dcnt_tc #(
  parameter int MODULUS = dcnt_pkg::DIGIT_MOD,
  parameter int W       = dcnt_pkg::DIGIT_W
) (
  input  logic [W-1:0] q,
  input  logic         carry_en,
  output logic         tc
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);

  assign tc = carry_en & (q == TERM);
endmodule

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter
  import dcnt_pkg::*;
#(
  parameter int MODULUS = DIGIT_MOD,
  parameter int W       = DIGIT_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] din,
  input  logic         cnt_en,
  input  logic         carry_en,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);

  dcnt_op_e     op;
  logic [W-1:0] nxt;

  dcnt_next #(.MODULUS(MODULUS), .W(W)) u_next (
    .cur      (q),
    .din      (din),
    .ld_n     (ld_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .op       (op),
    .nxt      (nxt)
  );

  dcnt_state #(.W(W)) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .nxt   (nxt),
    .q     (q)
  );

  dcnt_tc #(.MODULUS(MODULUS), .W(W)) u_tc (
    .q        (q),
    .carry_en (carry_en),
    .tc       (tc)
  );

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(din));

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && carry_en && q < TERM) |=> q == W'($past(q) + 1));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && tc) |=> q == '0);

  // R7
  range_recover_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && carry_en && q > TERM) |=> q == '0);

  // R7
  range_tc_low_chk: assert property (@(posedge clk) disable iff (!clr_n)
    q > TERM |-> !tc);
endmodule

// File: tb/bcd_digit_counter_tb.sv
module bcd_digit_counter_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic ld_n = 1'b1;
  logic en_p = 1'b0;
  logic en_t = 1'b0;
  logic [3:0] d0 = '0, d1 = '0, d2 = '0;
  logic [3:0] q0, q1, q2;
  logic tc0, tc1, tc2;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bcd_digit_counter u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(d0),
    .cnt_en(en_p), .carry_en(en_t), .q(q0), .tc(tc0));
  bcd_digit_counter u_tens (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(d1),
    .cnt_en(en_p), .carry_en(tc0), .q(q1), .tc(tc1));
  bcd_digit_counter u_hund (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(d2),
    .cnt_en(en_p), .carry_en(tc1), .q(q2), .tc(tc2));

  function automatic int chain_val();
    return int'(q2) * 100 + int'(q1) * 10 + int'(q0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    clr_n = 1'b0;
    #1;
    chk(chain_val() == 0, "R2 clear immediate", chain_val(), 0);
    clr_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state
    #1;
    clr_n = 1'b0;
    #1;
    chk(chain_val() == 0, "R2 reset state", chain_val(), 0);
    chk(tc0 == 1'b0, "R6 tc at reset", tc0, 0);
    // R2: clear overrides load and enables at an edge
    ld_n = 1'b0; d0 = 4'd7; d1 = 4'd3; d2 = 4'd2; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk(chain_val() == 0, "R2 clear beats load", chain_val(), 0);
    clr_n = 1'b1;
    ld_n = 1'b1; en_p = 1'b0;

    // R3: load with both enables high, count suppressed
    d0 = 4'd7; d1 = 4'd4; d2 = 4'd3; ld_n = 1'b0; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk(chain_val() == 347, "R3 load priority", chain_val(), 347);
    // R3: load with both enables low
    d0 = 4'd1; d1 = 4'd2; d2 = 4'd5; en_p = 1'b0; en_t = 1'b0;
    tick();
    chk(chain_val() == 521, "R3 load enables low", chain_val(), 521);
    ld_n = 1'b1;

    // R1: input changes between edges leave q alone
    #2;
    d0 = 4'd9; ld_n = 1'b0; en_p = 1'b1; en_t = 1'b1;
    #1;
    chk(chain_val() == 521, "R1 no change between edges", chain_val(), 521);
    ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0;

    // R4: hold for each enable combination short of both
    for (int c = 0; c < 3; c++) begin
      en_p = c[0]; en_t = c[1];
      tick();
      chk(chain_val() == 521, "R4 hold without both enables", chain_val(), 521);
    end

    // R6: tc with cnt_en low, carry_en high, at 9
    ld_n = 1'b0; d0 = 4'd9; d1 = 4'd0; d2 = 4'd0; en_p = 1'b0; en_t = 1'b1;
    tick();
    ld_n = 1'b1;
    #1;
    chk(tc0 == 1'b1, "R6 tc independent of cnt_en", tc0, 1);
    en_t = 1'b0;
    #1;
    chk(tc0 == 1'b0, "R6 tc gated by carry_en", tc0, 0);
    en_t = 1'b1;
    tick();
    chk(chain_val() == 9, "R4 hold with cnt_en low", chain_val(), 9);

    // R5/R7: every code loaded, then one enabled edge, both carry_en levels
    for (int v = 0; v < 16; v++) begin
      for (int et = 0; et < 2; et++) begin
        int exp_u;
        int exp_t;
        en_p = 1'b0; en_t = et[0];
        ld_n = 1'b0; d0 = 4'(v); d1 = 4'd0; d2 = 4'd0;
        tick();
        ld_n = 1'b1;
        #1;
        chk(int'(q0) == v, "R3 load each code", q0, v);
        chk(tc0 == (et == 1 && v == 9), "R6 R7 tc decode", tc0, int'(et == 1 && v == 9));
        en_p = 1'b1;
        tick();
        exp_u = (et == 0) ? v : ((v >= 9) ? 0 : v + 1);
        exp_t = (et == 1 && v == 9) ? 1 : 0;
        chk(int'(q0) == exp_u, "R5 R7 step from code", q0, exp_u);
        chk(int'(q1) == exp_t, "R8 carry into tens", q1, exp_t);
      end
    end

    // R8: full chain sweep 000..999 and wrap
    en_p = 1'b0;
    clear_all();
    en_p = 1'b1; en_t = 1'b1; ld_n = 1'b1;
    for (int i = 1; i <= 1005; i++) begin
      tick();
      chk(chain_val() == i % 1000, "R8 chain count", chain_val(), i % 1000);
      if (i == 999) begin
        chk(tc2 == 1'b1, "R6 R8 top tc at 999", tc2, 1);
      end
    end

    // R2: clear in the middle of a cycle, before the next edge
    repeat (3) tick();
    #2;
    clr_n = 1'b0;
    #1;
    chk(chain_val() == 0, "R2 mid-cycle clear", chain_val(), 0);
    tick();
    chk(chain_val() == 0, "R2 clear held over edge", chain_val(), 0);
    clr_n = 1'b1;
    tick();
    chk(chain_val() == 1, "R5 count after clear", chain_val(), 1);

    // R3/R8: load mid-count, then continue through a carry
    ld_n = 1'b0; d0 = 4'd8; d1 = 4'd9; d2 = 4'd4;
    tick();
    ld_n = 1'b1;
    chk(chain_val() == 498, "R3 mid-count load", chain_val(), 498);
    repeat (4) tick();
    chk(chain_val() == 502, "R8 carry ripple after load", chain_val(), 502);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule